// File: doc/BRIEF.md
# Prescaled Input Capture Channel

This block records when edges occur on one external input. The input passes through a two-flop synchronizer and an edge detector. A 3-bit mode code then chooses which edges count as capture events. On each capture event, the current value of a free-running 16-bit time-base bus is pushed into a four-entry FIFO. Software removes values with a one-cycle read strobe and watches a not-empty flag. That flag drops by itself once the last stored value has been read.

Interrupts are paced separately from captures. A 2-bit selector asks for one interrupt pulse every 1, 2, 3 or 4 capture events. A capture that finds the FIFO full is lost, and it raises a sticky overflow flag. An external hold input, driven by a synchronization source, keeps the channel idle and keeps its counters cleared for as long as it is high.

Top module: `icap_channel`

## Requirements
- R1: Mode codes 000, 010, 110 and 111 perform no captures. No capture occurs in any mode while `sync_hold_i` is high.
- R2: Mode 001 captures on every transition of the input, rising or falling.
- R3: Mode 011 captures on every rising edge. Falling edges are ignored.
- R4: Modes 100 and 101 capture on every 4th and every 16th rising edge respectively. After the counter has been cleared, the first capture lands on the 4th or 16th rising edge.
- R5: The stored value is the time-base value at the clock edge two cycles after the first clock edge that samples the new input level.
- R6: Captures are read out oldest first. `rd_data_o` shows the oldest entry, and a high `rd_i` removes it. `not_empty_o` is high while at least one entry is stored and clears when the last entry is read. A read of an empty FIFO changes nothing.
- R7: A capture into a full four-entry FIFO is dropped and sets `overflow_o`. The flag stays set until the loaded mode is 000, which clears it one cycle later.
- R8: `irq_o` pulses for one cycle after every (N+1)-th capture event, where N is `irq_every_i`. Dropped captures count as events. The pulse comes in the cycle in which the capture is stored.
- R9: A mode write (`mode_wr_i` high) clears the edge prescaler and the interrupt counter, even when the same mode is written again.
- R10: While `sync_hold_i` is high, the edge prescaler and the interrupt counter are held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Capture mode code, loaded by `mode_wr_i` |
| mode_wr_i | input | 1 | One-cycle strobe that loads `mode_i` |
| irq_every_i | input | 2 | Interrupt pacing: one pulse per value+1 captures |
| sync_hold_i | input | 1 | Holds the channel idle and its counters cleared |
| pin_i | input | 1 | Asynchronous input being timestamped |
| timebase_i | input | 16 | Free-running time-base value |
| rd_i | input | 1 | Read strobe, removes the oldest entry |
| rd_data_o | output | 16 | Oldest stored timestamp |
| not_empty_o | output | 1 | At least one entry is stored |
| overflow_o | output | 1 | Sticky flag: a capture was dropped |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench sweeps every mode code against every interrupt setting, with 34 transitions in each combination. It predicts every timestamp and every interrupt count arithmetically. Against this sweep, a prescaler that fires on the wrong edge, or one that counts falling edges, shows up as missing or extra FIFO entries. A wrong synchronizer depth shows up as timestamps off by a cycle.

Separate scenarios target the remaining corner cases:
- A filled FIFO checks that a design overwriting old data would corrupt the read-out order, and that a flag that is not sticky would read low after draining.
- A re-written mode and a pulsed hold check the counter resets: a prescaler that survived either would capture too early.
- A read of an empty FIFO checks that a pointer that moves anyway would surface stale data.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [2:0] {
    CAP_OFF    = 3'd0,
    CAP_ANY    = 3'd1,
    CAP_RSV2   = 3'd2,
    CAP_RISE   = 3'd3,
    CAP_RISE4  = 3'd4,
    CAP_RISE16 = 3'd5,
    CAP_RSV6   = 3'd6,
    CAP_RSV7   = 3'd7
  } cap_mode_e;

  // True for codes that produce captures
  function automatic logic mode_active(cap_mode_e m);
    return (m == CAP_ANY) || (m == CAP_RISE) || (m == CAP_RISE4) || (m == CAP_RISE16);
  endfunction

  // True for codes that divide rising edges
  function automatic logic mode_divided(cap_mode_e m);
    return (m == CAP_RISE4) || (m == CAP_RISE16);
  endfunction

  // Number of rising edges per capture in a divided mode
  function automatic int prescale_len(cap_mode_e m, int lo_div, int hi_div);
    case (m)
      CAP_RISE4:  return lo_div;
      CAP_RISE16: return hi_div;
      default:    return 1;
    endcase
  endfunction

endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;
  logic              synced;

  assign synced = sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      prev <= synced;
    end
  end

  assign rise = synced & ~prev;
  assign fall = ~synced & prev;
endmodule

// File: rtl/icap_prescale.sv
module icap_prescale
  import icap_pkg::*;
#(
  parameter int LO_DIV = 4,
  parameter int HI_DIV = 16,
  localparam int PS_W  = $clog2(HI_DIV)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      restart,
  input  cap_mode_e mode,
  input  logic      rise,
  input  logic      fall,
  output logic      fire
);
  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] last;
  logic            raw;

  assign last = PS_W'(prescale_len(mode, LO_DIV, HI_DIV) - 1);

  always_comb begin
    case (mode)
      CAP_ANY:               raw = rise | fall;
      CAP_RISE:              raw = rise;
      CAP_RISE4, CAP_RISE16: raw = rise && (pcnt == last);
      default:               raw = 1'b0;
    endcase
  end

  assign fire = en & raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (!en || restart)
      pcnt <= '0;
    else if (rise && mode_divided(mode))
      pcnt <= (pcnt == last) ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign drop    = push & full;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/icap_irq_div.sv
module icap_irq_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic [SEL_W-1:0] sel,
  output logic             irq
);
  logic [SEL_W-1:0] cnt;

  // Reached the selected count of prior events
  function automatic logic due(logic [SEL_W-1:0] c, logic [SEL_W-1:0] s);
    return c >= s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= evt && due(cnt, sel);
      if (evt) cnt <= due(cnt, sel) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LO_DIV      = 4,
  parameter int HI_DIV      = 16,
  parameter int SEL_W       = 2,
  localparam int LVL_W      = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             mode_wr_i,
  input  logic [SEL_W-1:0] irq_every_i,
  input  logic             sync_hold_i,
  input  logic             pin_i,
  input  logic [TB_W-1:0]  timebase_i,
  input  logic             rd_i,
  output logic [TB_W-1:0]  rd_data_o,
  output logic             not_empty_o,
  output logic             overflow_o,
  output logic             irq_o
);
  cap_mode_e        mode_q;
  logic             run;
  logic             edge_rise, edge_fall;
  logic             cap_evt;
  logic             fifo_drop, fifo_empty;
  logic [LVL_W-1:0] fifo_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= CAP_OFF;
    else if (mode_wr_i) mode_q <= cap_mode_e'(mode_i);
  end

  assign run = mode_active(mode_q) & ~sync_hold_i;

  icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .pin (pin_i),
    .rise (edge_rise),
    .fall (edge_fall)
  );

  icap_prescale #(.LO_DIV(LO_DIV), .HI_DIV(HI_DIV)) u_ps (
    .clk (clk),
    .rst_n (rst_n),
    .en (run),
    .restart (mode_wr_i),
    .mode (mode_q),
    .rise (edge_rise),
    .fall (edge_fall),
    .fire (cap_evt)
  );

  icap_fifo #(.W(TB_W), .DEPTH(DEPTH)) u_fifo (
    .clk (clk),
    .rst_n (rst_n),
    .push (cap_evt),
    .wdata (timebase_i),
    .pop (rd_i),
    .rdata (rd_data_o),
    .level (fifo_level),
    .empty (fifo_empty),
    .drop (fifo_drop)
  );

  icap_irq_div #(.SEL_W(SEL_W)) u_irq (
    .clk (clk),
    .rst_n (rst_n),
    .clr (mode_wr_i | sync_hold_i),
    .evt (cap_evt),
    .sel (irq_every_i),
    .irq (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                overflow_o <= 1'b0;
    else if (mode_q == CAP_OFF) overflow_o <= 1'b0;
    else if (fifo_drop)        overflow_o <= 1'b1;
  end

  assign not_empty_o = ~fifo_empty;
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic [2:0]       mode_q,
  input logic             rd,
  input logic             cap_evt,
  input logic [LVL_W-1:0] fifo_level,
  input logic             not_empty,
  input logic             overflow,
  input logic             irq
);
  // R1
  a_r1_idle_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 || hold) |-> !cap_evt);

  // R6
  a_r6_drain_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == LVL_W'(1) && rd && !cap_evt) |=> !not_empty);

  // R6
  a_r6_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && rd && !cap_evt) |=> !not_empty);

  // R7
  a_r7_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && fifo_level == LVL_W'(DEPTH) && mode_q != 3'd0) |=> overflow);

  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && mode_q != 3'd0) |=> overflow);

  // R8
  a_r8_irq_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cap_evt));

  // R6
  always @(posedge clk) begin
    if (rst_n) a_r6_level_bound: assert (fifo_level <= LVL_W'(DEPTH));
  end
endmodule

bind icap_channel icap_channel_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .hold (sync_hold_i),
  .mode_q (mode_q),
  .rd (rd_i),
  .cap_evt (cap_evt),
  .fifo_level (fifo_level),
  .not_empty (not_empty_o),
  .overflow (overflow_o),
  .irq (irq_o)
);

// File: tb/tb_icap_channel.sv
module tb_icap_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        mode_wr_i = 1'b0;
  logic [1:0]  irq_every_i = 2'd0;
  logic        sync_hold_i = 1'b0;
  logic        pin_i = 1'b0;
  logic [15:0] timebase_i = 16'd0;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        not_empty_o, overflow_o, irq_o;

  icap_channel dut (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .mode_wr_i (mode_wr_i),
    .irq_every_i (irq_every_i), .sync_hold_i (sync_hold_i), .pin_i (pin_i),
    .timebase_i (timebase_i), .rd_i (rd_i), .rd_data_o (rd_data_o),
    .not_empty_o (not_empty_o), .overflow_o (overflow_o), .irq_o (irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int irq_seen = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && irq_o) irq_seen <= irq_seen + 1;
  end
  always @(negedge clk) timebase_i = cyc[15:0];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Model state
  logic [15:0] mq[$];
  int  pc = 0;
  int  ic = 0;
  int  irq_exp = 0;
  bit  ovf_exp = 1'b0;
  int  cur_mode = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(int m);
    case (m)
      1:       return "R2";
      3:       return "R3";
      4, 5:    return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic wr_mode(int m);
    mode_i = m[2:0];
    mode_wr_i = 1'b1;
    @(negedge clk);
    mode_wr_i = 1'b0;
    cur_mode = m;
    pc = 0;
    ic = 0;
    if (m == 0) ovf_exp = 1'b0;
  endtask

  task automatic set_hold(bit h);
    sync_hold_i = h;
    if (h) begin pc = 0; ic = 0; end
    @(negedge clk);
  endtask

  // Toggle the pin, predict the outcome, wait for it to settle
  task automatic toggle();
    bit rise;
    bit ev;
    int lim;
    rise = !pin_i;
    ev = 1'b0;
    if (!sync_hold_i) begin
      case (cur_mode)
        1: ev = 1'b1;
        3: ev = rise;
        4, 5: begin
          lim = 1 << (2 * (cur_mode - 3));
          if (rise) begin
            pc++;
            if (pc == lim) begin pc = 0; ev = 1'b1; end
          end
        end
        default: ev = 1'b0;
      endcase
    end
    if (ev) begin
      if (ic >= int'(irq_every_i)) begin ic = 0; irq_exp++; end
      else ic++;
      if (mq.size() < 4) mq.push_back(16'(cyc + 2));
      else ovf_exp = 1'b1;
    end
    pin_i = rise;
    repeat (5) @(negedge clk);
    check(irq_seen == irq_exp, "R8", "irq pulse count", irq_seen, irq_exp);
  endtask

  task automatic pop_one(string req);
    logic [15:0] e;
    e = mq.pop_front();
    check(not_empty_o == 1'b1, "R6", "not_empty before read", not_empty_o, 1);
    check(rd_data_o == e, req, "timestamp (R5)", rd_data_o, e);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic drain(string req);
    while (mq.size() > 0) pop_one(req);
    check(not_empty_o == 1'b0, "R6", "not_empty after drain", not_empty_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(not_empty_o == 1'b0, "R6", "reset not_empty", not_empty_o, 0);
    check(overflow_o == 1'b0, "R7", "reset overflow", overflow_o, 0);
    check(irq_o == 1'b0, "R8", "reset irq", irq_o, 0);

    // Sweep of every mode code against every interrupt pacing
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 4; s++) begin
        irq_every_i = s[1:0];
        wr_mode(m);
        for (int t = 0; t < 34; t++) begin
          toggle();
          if (mq.size() == 0)
            check(not_empty_o == 1'b0, mode_req(m), "no capture expected", not_empty_o, 0);
          drain(mode_req(m));
        end
        check(overflow_o == 1'b0, "R7", "no overflow in sweep", overflow_o, 0);
      end
    end

    // R1: hold blocks captures
    irq_every_i = 2'd0;
    wr_mode(3);
    set_hold(1'b1);
    for (int t = 0; t < 4; t++) toggle();
    check(not_empty_o == 1'b0, "R1", "capture while held", not_empty_o, 0);
    set_hold(1'b0);

    // R10: hold clears the prescaler
    wr_mode(4);
    for (int t = 0; t < 4; t++) toggle();
    set_hold(1'b1);
    set_hold(1'b0);
    for (int t = 0; t < 6; t++) toggle();
    check(not_empty_o == 1'b0, "R10", "prescaler cleared by hold", not_empty_o, 0);
    for (int t = 0; t < 2; t++) toggle();
    check(not_empty_o == 1'b1, "R10", "4th rise after hold", not_empty_o, 1);
    drain("R10");

    // R9: re-writing the same mode clears the prescaler and irq counter
    irq_every_i = 2'd1;
    wr_mode(4);
    for (int t = 0; t < 6; t++) toggle();
    wr_mode(4);
    for (int t = 0; t < 2; t++) toggle();
    check(not_empty_o == 1'b0, "R9", "prescaler cleared by write", not_empty_o, 0);
    for (int t = 0; t < 6; t++) toggle();
    check(not_empty_o == 1'b1, "R9", "4th rise after write", not_empty_o, 1);
    drain("R9");

    // R7: overflow keeps oldest four, sets sticky flag
    irq_every_i = 2'd0;
    wr_mode(3);
    for (int t = 0; t < 12; t++) toggle();
    check(overflow_o == ovf_exp, "R7", "overflow set", overflow_o, ovf_exp);
    drain("R7");
    check(overflow_o == 1'b1, "R7", "overflow sticky", overflow_o, 1);
    wr_mode(0);
    @(negedge clk);
    check(overflow_o == 1'b0, "R7", "overflow cleared by mode 000", overflow_o, 0);

    // R6: read of an empty FIFO is ignored
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check(not_empty_o == 1'b0, "R6", "empty read", not_empty_o, 0);
    wr_mode(3);
    for (int t = 0; t < 2; t++) toggle();
    check(not_empty_o == 1'b1, "R6", "single entry", not_empty_o, 1);
    drain("R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule